// File: doc/BRIEF.md
# Zero-Crossing Gain Update Controller

This block sits between the gain field of a preamplifier's control register and the gain switches of the analog path. It turns the 6-bit gain code into a gain in dB and decides in which clock cycle that gain is actually applied. A hardware pin can force unity gain at any time. When zero-cross mode is on, a new gain waits for the input signal to change sign, or for a timeout, so that gain steps fall near a zero crossing. The block also merges the servo-disable pin with the servo-disable register bit into one servo enable.

The gain code and load strobe come from the register logic in the system clock domain. The unity, zero-cross enable and servo pins are taken as already synchronous. The sign bit from the input comparator is asynchronous and goes through a synchronizer first. A one-cycle pulse marks every cycle in which the applied gain changes.

Top module: `zc_gain_ctrl`

## Requirements
- R1: The applied gain `gain_db` is an unsigned binary dB value. Code 0 gives 0, codes 1 to 56 give code + 9, and codes 57 to 63 give 65.
- R2: While `unity_force` is high at a clock edge, `gain_db` is 0 after that edge, in zero-cross mode as well.
- R3: A code loaded while `unity_force` is high changes nothing until the pin goes low. After that the gain from that code is applied under the rule of the current mode (R5 or R6).
- R4: With `zc_enable` high, a pending gain is applied at the third rising edge after `sign_in` changes level. The gain is never applied in a cycle with no sign change, no timeout and no unity force.
- R5: With `zc_enable` high and no sign change, a gain loaded at edge k is applied at edge k + TIMEOUT_CYC.
- R6: With `zc_enable` low, a gain loaded at edge k is applied at edge k + 1.
- R7: A load while a gain is still pending replaces it, so the earlier value is never applied. The timeout restarts from the new load.
- R8: `servo_en` is 0 one cycle after `servo_off_pin` or `servo_off_bit` is 1, and 1 one cycle after both are 0.
- R9: `gain_step` is high for exactly the cycles in which `gain_db` has just taken a new value. Loading a code that maps to the gain already applied gives no pulse.
- R10: During reset, `gain_db` is 0 and both `gain_step` and `servo_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| gain_code | input | CODE_W | Gain code from the control register |
| load_stb | input | 1 | One-cycle strobe: gain_code holds a newly written value |
| unity_force | input | 1 | Forces 0 dB while high |
| zc_enable | input | 1 | High: gain changes wait for a sign change or a timeout |
| servo_off_pin | input | 1 | Servo-disable pin, active high |
| servo_off_bit | input | 1 | Servo-disable register bit, active high |
| sign_in | input | 1 | Asynchronous sign bit from the input comparator |
| gain_db | output | DB_W | Applied gain in dB |
| gain_step | output | 1 | Pulse in the cycle after the applied gain changed |
| servo_en | output | 1 | Servo enable |

## Verification
The bench builds the block with TIMEOUT_CYC = 64 and SYNC_STAGES = 2, keeping the default code and dB widths. The short timeout makes every cycle of the timeout window reachable: the bench checks the gain one cycle before and in the cycle of the timeout, after a plain load, after a load that replaces a pending one, and after the unity pin is released. With two synchronizer stages, the delay from a sign change to the applied gain is a known three edges, so it can be checked exactly. A sweep over all 64 codes in direct mode covers the whole dB mapping, including both saturation edges.

// File: rtl/zc_gain_pkg.sv
package zc_gain_pkg;

  // Source of a gain update in a given cycle
  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_FORCE   = 3'd1,
    SRC_DIRECT  = 3'd2,
    SRC_CROSS   = 3'd3,
    SRC_TIMEOUT = 3'd4
  } apply_src_e;

  // Code to dB: zero stays zero, then a fixed offset, clipped at a ceiling
  function automatic int unsigned code_to_db(input int unsigned code,
                                             input int unsigned offset_db,
                                             input int unsigned ceil_db);
    if (code == 0)
      return 0;
    else if (code + offset_db >= ceil_db)
      return ceil_db;
    else
      return code + offset_db;
  endfunction

endpackage

// File: rtl/gz_gain_map.sv
module gz_gain_map #(
  parameter int unsigned CODE_W    = 6,
  parameter int unsigned DB_W      = 7,
  parameter int unsigned OFFSET_DB = 9,
  parameter int unsigned CEIL_DB   = 65
) (
  input  logic [CODE_W-1:0] code_in,
  output logic [DB_W-1:0]   db_out
);
  import zc_gain_pkg::*;

  always_comb begin
    db_out = DB_W'(code_to_db(32'(code_in), OFFSET_DB, CEIL_DB));
  end

  // R1: the mapped value never exceeds the ceiling
  always_comb begin
    map_ceil_chk: assert (32'(db_out) <= CEIL_DB)
      else $error("mapped gain above ceiling");
  end

endmodule

// File: rtl/gz_sign_sync.sv
module gz_sign_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sign_in,
  output logic sign_cross
);
  // chain[STAGES-1] is the synchronized sign, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= sign_in;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign sign_cross = chain[STAGES-1] ^ chain[STAGES];

  // R4: no crossing is reported while the input has been steady long enough
  no_spurious_cross_chk: assert property (@(posedge clk) disable iff (rst)
    sign_cross |-> $past(chain[STAGES-1]) != chain[STAGES-1] || $past(rst))
    else $error("crossing without a sign change");

endmodule

// File: rtl/gz_hold_timer.sv
module gz_hold_timer #(
  parameter int unsigned TIMEOUT_CYC = 800000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic armed,
  output logic expire
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (armed)     cnt <= cnt + 1'b1;
  end

  assign expire = armed && (cnt == LAST);

  // R5: the count never runs past the timeout window
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST)
    else $error("timeout counter overran");

endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl #(
  parameter int unsigned CODE_W      = 6,
  parameter int unsigned DB_W        = 7,
  parameter int unsigned OFFSET_DB   = 9,
  parameter int unsigned CEIL_DB     = 65,
  parameter int unsigned TIMEOUT_CYC = 800000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] gain_code,
  input  logic              load_stb,
  input  logic              unity_force,
  input  logic              zc_enable,
  input  logic              servo_off_pin,
  input  logic              servo_off_bit,
  input  logic              sign_in,
  output logic [DB_W-1:0]   gain_db,
  output logic              gain_step,
  output logic              servo_en
);
  import zc_gain_pkg::*;

  logic [CODE_W-1:0] req_code_q;
  logic [DB_W-1:0]   req_db;
  logic [DB_W-1:0]   desired_db;
  logic [DB_W-1:0]   gain_db_q;
  logic              step_q;
  logic              servo_q;
  logic              sign_cross;
  logic              tmo_hit;
  logic              pending;
  logic              apply_now;
  logic              tmr_restart;
  apply_src_e        src;

  // Requested code: kept even while the unity pin overrides it
  always_ff @(posedge clk) begin
    if (rst)           req_code_q <= '0;
    else if (load_stb) req_code_q <= gain_code;
  end

  gz_gain_map #(
    .CODE_W   (CODE_W),
    .DB_W     (DB_W),
    .OFFSET_DB(OFFSET_DB),
    .CEIL_DB  (CEIL_DB)
  ) u_map (
    .code_in(req_code_q),
    .db_out (req_db)
  );

  gz_sign_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sign_in   (sign_in),
    .sign_cross(sign_cross)
  );

  assign tmr_restart = load_stb | ~pending | apply_now;

  gz_hold_timer #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .restart(tmr_restart),
    .armed  (pending),
    .expire (tmo_hit)
  );

  // Target gain and the reason, if any, to apply it in this cycle
  always_comb begin
    desired_db = unity_force ? '0 : req_db;
    pending    = (desired_db != gain_db_q);
    src        = SRC_NONE;
    if (pending) begin
      if (unity_force)     src = SRC_FORCE;
      else if (!zc_enable) src = SRC_DIRECT;
      else if (sign_cross) src = SRC_CROSS;
      else if (tmo_hit)    src = SRC_TIMEOUT;
    end
    apply_now = (src != SRC_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_db_q <= '0;
      step_q    <= 1'b0;
      servo_q   <= 1'b0;
    end else begin
      if (apply_now) gain_db_q <= desired_db;
      step_q  <= apply_now;
      servo_q <= ~(servo_off_pin | servo_off_bit);
    end
  end

  assign gain_db   = gain_db_q;
  assign gain_step = step_q;
  assign servo_en  = servo_q;

  // R2
  unity_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(unity_force) |-> gain_db == '0)
    else $error("gain not forced to unity");

  // R4
  zc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(zc_enable) && !$past(unity_force) && !$past(sign_cross) && !$past(tmo_hit))
      |-> $stable(gain_db))
    else $error("gain moved without crossing or timeout");

  // R9
  step_change_chk: assert property (@(posedge clk) disable iff (rst)
    gain_step |-> gain_db != $past(gain_db))
    else $error("step pulse without gain change");

  // R9
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !gain_step |-> $stable(gain_db))
    else $error("gain changed without step pulse");

  // R8
  servo_off_chk: assert property (@(posedge clk) disable iff (rst)
    servo_en |-> !$past(servo_off_pin) && !$past(servo_off_bit))
    else $error("servo enabled while disabled");

endmodule

// File: tb/zc_gain_ctrl_tb.sv
module zc_gain_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 64;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] gain_code = '0;
  logic       load_stb = 1'b0;
  logic       unity_force = 1'b0;
  logic       zc_enable = 1'b0;
  logic       servo_off_pin = 1'b0;
  logic       servo_off_bit = 1'b0;
  logic       sign_in = 1'b0;
  logic [6:0] gain_db;
  logic       gain_step;
  logic       servo_en;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;
  int exp_q[$];
  int last_db  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_gain_ctrl #(
    .TIMEOUT_CYC(TMO),
    .SYNC_STAGES(2)
  ) u_dut (
    .clk          (clk),
    .rst          (rst),
    .gain_code    (gain_code),
    .load_stb     (load_stb),
    .unity_force  (unity_force),
    .zc_enable    (zc_enable),
    .servo_off_pin(servo_off_pin),
    .servo_off_bit(servo_off_bit),
    .sign_in      (sign_in),
    .gain_db      (gain_db),
    .gain_step    (gain_step),
    .servo_en     (servo_en)
  );

  function automatic int model_db(input int code);
    if (code == 0) return 0;
    if (code + 9 >= 65) return 65;
    return code + 9;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // Driver side: expect a new applied gain if it differs from the last one
  task automatic expect_db(input int db);
    if (db != last_db) begin
      exp_q.push_back(db);
      last_db = db;
    end
  endtask

  task automatic load(input int code);
    @(negedge clk);
    gain_code = 6'(code);
    load_stb  = 1'b1;
    @(negedge clk);
    load_stb  = 1'b0;
  endtask

  // Monitor: every step pulse must match the next expected gain (R9)
  always @(negedge clk) begin
    if (!rst && !done && gain_step) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected step", int'(gain_db), last_db);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(gain_db) == e, "R9 step value", int'(gain_db), e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(gain_db == 0, "R10 gain in reset", int'(gain_db), 0);
    chk(gain_step == 0, "R10 step in reset", int'(gain_step), 0);
    chk(servo_en == 0, "R10 servo in reset", int'(servo_en), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(servo_en == 1, "R8 servo after reset", int'(servo_en), 1);

    // R1 / R6: direct mode, sweep all codes
    for (int c = 0; c < 64; c++) begin
      int prev;
      prev = last_db;
      expect_db(model_db(c));
      load(c);
      chk(int'(gain_db) == prev, "R6 not before edge k+1", int'(gain_db), prev);
      @(negedge clk);
      chk(int'(gain_db) == model_db(c), "R1 code map", int'(gain_db), model_db(c));
    end

    // R9: same gain reloaded, no pulse
    load(60);
    repeat (3) @(negedge clk);
    chk(gain_db == 65 && gain_step == 0, "R9 no step on same gain", int'(gain_db), 65);

    // R2 / R3: unity override in direct mode
    @(negedge clk);
    unity_force = 1'b1;
    expect_db(0);
    @(negedge clk);
    chk(gain_db == 0, "R2 unity forces zero", int'(gain_db), 0);
    load(40);
    repeat (4) @(negedge clk);
    chk(gain_db == 0, "R3 held under unity", int'(gain_db), 0);
    unity_force = 1'b0;
    expect_db(49);
    @(negedge clk);
    chk(gain_db == 49, "R3 applied after release", int'(gain_db), 49);

    // R8: servo enable from pin and bit
    servo_off_pin = 1'b1;
    @(negedge clk);
    chk(servo_en == 0, "R8 pin disables", int'(servo_en), 0);
    servo_off_pin = 1'b0;
    @(negedge clk);
    chk(servo_en == 1, "R8 re-enabled", int'(servo_en), 1);
    servo_off_bit = 1'b1;
    @(negedge clk);
    chk(servo_en == 0, "R8 bit disables", int'(servo_en), 0);
    servo_off_bit = 1'b0;
    @(negedge clk);
    chk(servo_en == 1, "R8 re-enabled again", int'(servo_en), 1);

    // R5: zero-cross mode, timeout with steady sign
    zc_enable = 1'b1;
    expect_db(29);
    load(20);
    for (int j = 1; j <= TMO; j++) begin
      @(negedge clk);
      if (j == TMO - 1) chk(gain_db == 49, "R5 held before timeout", int'(gain_db), 49);
      if (j == TMO)     chk(gain_db == 29, "R5 applied at timeout", int'(gain_db), 29);
    end

    // R4: applied on sign change
    expect_db(39);
    load(30);
    repeat (5) @(negedge clk);
    chk(gain_db == 29, "R4 held without crossing", int'(gain_db), 29);
    sign_in = ~sign_in;
    @(negedge clk);
    @(negedge clk);
    chk(gain_db == 29, "R4 not before third edge", int'(gain_db), 29);
    @(negedge clk);
    chk(gain_db == 39, "R4 applied at crossing", int'(gain_db), 39);

    // R7: pending value replaced, timeout restarts
    load(10);
    repeat (30) @(negedge clk);
    expect_db(59);
    load(50);
    for (int j = 1; j <= TMO; j++) begin
      @(negedge clk);
      if (j == TMO - 1) chk(gain_db == 39, "R7 restart holds old gain", int'(gain_db), 39);
      if (j == TMO)     chk(gain_db == 59, "R7 replacement applied", int'(gain_db), 59);
    end

    // R2 / R3 in zero-cross mode
    @(negedge clk);
    unity_force = 1'b1;
    expect_db(0);
    @(negedge clk);
    chk(gain_db == 0, "R2 unity immediate in zc mode", int'(gain_db), 0);
    load(45);
    repeat (3) @(negedge clk);
    unity_force = 1'b0;
    expect_db(54);
    for (int j = 1; j <= TMO; j++) begin
      @(negedge clk);
      if (j == 1)       chk(gain_db == 0, "R3 waits after release", int'(gain_db), 0);
      if (j == TMO - 1) chk(gain_db == 0, "R3 held until timeout", int'(gain_db), 0);
      if (j == TMO)     chk(gain_db == 54, "R3 applied at timeout", int'(gain_db), 54);
    end

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all expected steps seen", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule